// File: doc/BRIEF.md
# I2C Bus Clear Recovery Controller

This unit sits beside an I2C master and, when asked, tries to free a bus on which a slave is holding SDA low. A typical cause is a slave that was interrupted mid-byte and is still driving a data bit. The unit reaches both bus lines only through open-drain pad controls. It reads the line levels and drives a pull-low enable for each line. A line goes high only because its enable is released, so the unit never fights a line that is shorted to ground.

On a start request the unit first looks at the synchronised line levels. If both lines are high, the bus is already free and the unit reports success at once. If SCL stays low for a configurable timeout, the unit raises a stuck-clock fault and toggles nothing, because only a device reset or a power cycle can clear that. If SCL is high and SDA is low, the unit issues SCL pulses one at a time and looks at SDA at the end of every high phase. It stops pulsing as soon as SDA is high and then ends with a STOP condition. The high phase of every pulse is timed from the moment SCL is seen high, so a slave that stretches the clock is honoured. After a set number of pulses without success the unit reports that recovery failed. The status outputs stay valid until the next start request.

Top module: `i2c_bus_unhang`

## Requirements
- R1: When a start request finds both lines high, the unit reports done with a pulse count of 0. It asserts neither pull-low enable and produces no STOP.
- R2: When SCL reads low for STUCK_LIMIT consecutive cycles in the initial check, the unit reports the stuck-clock fault. Neither pull-low enable is ever asserted in that run.
- R3: When a start request finds SCL high and SDA low, recovery begins with an SCL pulse. A pulse is the SCL pull-low enable asserted and then released. The outputs are pull-low enables only, active high.
- R4: The SDA pull-low enable is asserted only as part of the STOP sequence. It rises only while the SCL pull-low enable is already asserted, so the unit never produces a START.
- R5: SDA is sampled at the end of each SCL high phase. Pulsing stops after the first pulse that ends with SDA high, and the pulse count output equals the number of pulses issued.
- R6: The high phase of a pulse lasts HALF_CYCLES cycles, counted only once the synchronised SCL reads high. A slave that holds SCL low after release therefore lengthens the pulse.
- R7: The unit issues at most MAX_PULSES pulses (9 by default). If SDA is still low after the last one, it reports failed, with a pulse count of MAX_PULSES and no STOP.
- R8: The STOP sequence runs in this order: SCL pulled low, then SDA pulled low as well, then SCL released, then SDA released. SDA therefore rises while SCL is high. Done is reported only if both lines then read high; otherwise failed is reported.
- R9: If SCL stays low for STUCK_LIMIT cycles while the unit waits for a released SCL to rise, the unit reports the stuck-clock fault.
- R10: Each SCL low phase of a recovery pulse keeps the SCL pull-low enable asserted for exactly HALF_CYCLES cycles.
- R11: At most one of done, stuck-clock and failed is high at a time. The status is held until the next start request, and a start request while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a bus clear attempt |
| scl_i | input | 1 | Sensed SCL level from the pad |
| sda_i | input | 1 | Sensed SDA level from the pad |
| scl_pull_o | output | 1 | SCL pull-low enable (1 = drive low, 0 = release) |
| sda_pull_o | output | 1 | SDA pull-low enable (1 = drive low, 0 = release) |
| busy_o | output | 1 | An attempt is in progress |
| done_o | output | 1 | Bus confirmed free |
| clk_stuck_o | output | 1 | SCL held low, recovery not possible |
| fail_o | output | 1 | SDA still held after all pulses, or STOP not confirmed |
| pulse_cnt_o | output | $clog2(MAX_PULSES+1) | Pulses issued in the last attempt |

## Verification
The recovery path is run with a slave model that lets go of SDA after 1, 3, 5 and 9 SCL falling edges. These runs show that pulsing stops on the first pulse that ends with SDA high. The 9 case is the pulse limit. A slave that never lets go of SDA separates the failed outcome from the limit case. An idle bus and an SCL shorted low show that the unit reports success or a fault without touching either line. One run has a slave that stretches the clock on the second pulse, and another has a slave that never releases SCL. Together they separate a high phase timed from the observed rise from a phase that times out as a stuck clock.

// File: rtl/busclr_pkg.sv
package busclr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PULSE_LOW,
    ST_PULSE_HIGH,
    ST_SAMPLE,
    ST_STOP_SETUP,
    ST_STOP_RELEASE,
    ST_DONE,
    ST_FAULT
  } rcv_state_t;

  // sub-steps of the STOP sequence
  localparam logic [1:0] STOP_CLK_LOW  = 2'd0;
  localparam logic [1:0] STOP_DATA_LOW = 2'd1;
  localparam logic [1:0] STOP_CLK_REL  = 2'd2;
endpackage

// File: rtl/busclr_sync.sv
module busclr_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= RESET_VAL;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RESET_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/busclr_tick_counter.sv
module busclr_tick_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);
  localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign expired = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || expired) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst) !en |=> cnt == '0);
endmodule

// File: rtl/i2c_bus_unhang.sv
module i2c_bus_unhang
  import busclr_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = 250,
  parameter int unsigned STUCK_LIMIT = 100000,
  parameter int unsigned MAX_PULSES  = 9,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_pull_o,
  output logic          sda_pull_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          clk_stuck_o,
  output logic          fail_o,
  output logic [CW-1:0] pulse_cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PULSES);

  logic scl_s, sda_s;
  logic half_run, half_exp, tmo_run, tmo_exp;

  rcv_state_t st, st_n;
  logic [1:0]    step, step_n;
  logic [CW-1:0] cnt, cnt_n;
  logic set_done, set_stuck, set_fail, clr_status;

  busclr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
  busclr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

  busclr_tick_counter #(.LIMIT(HALF_CYCLES)) u_phase_tmr (
    .clk(clk), .rst(rst), .en(half_run), .expired(half_exp));
  busclr_tick_counter #(.LIMIT(STUCK_LIMIT)) u_stuck_tmr (
    .clk(clk), .rst(rst), .en(tmo_run), .expired(tmo_exp));

  always_comb begin
    st_n       = st;
    step_n     = step;
    cnt_n      = cnt;
    half_run   = 1'b0;
    tmo_run    = 1'b0;
    set_done   = 1'b0;
    set_stuck  = 1'b0;
    set_fail   = 1'b0;
    clr_status = 1'b0;
    unique case (st)
      ST_IDLE, ST_DONE, ST_FAULT: begin
        if (start_i) begin
          st_n       = ST_CHECK;
          step_n     = STOP_CLK_LOW;
          cnt_n      = '0;
          clr_status = 1'b1;
        end
      end
      ST_CHECK: begin
        if (!scl_s) begin
          tmo_run = 1'b1;
          if (tmo_exp) begin
            st_n      = ST_FAULT;
            set_stuck = 1'b1;
          end
        end else if (sda_s) begin
          st_n     = ST_DONE;
          set_done = 1'b1;
        end else begin
          st_n = ST_PULSE_LOW;
        end
      end
      ST_PULSE_LOW: begin
        half_run = 1'b1;
        if (half_exp) st_n = ST_PULSE_HIGH;
      end
      ST_PULSE_HIGH: begin
        if (!scl_s) begin
          tmo_run = 1'b1;
          if (tmo_exp) begin
            st_n      = ST_FAULT;
            set_stuck = 1'b1;
          end
        end else begin
          half_run = 1'b1;
          if (half_exp) st_n = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        cnt_n = cnt + 1'b1;
        if (sda_s) begin
          st_n   = ST_STOP_SETUP;
          step_n = STOP_CLK_LOW;
        end else if (cnt_n == CNT_MAX) begin
          st_n     = ST_FAULT;
          set_fail = 1'b1;
        end else begin
          st_n = ST_PULSE_LOW;
        end
      end
      ST_STOP_SETUP: begin
        if (step == STOP_CLK_REL) begin
          if (!scl_s) begin
            tmo_run = 1'b1;
            if (tmo_exp) begin
              st_n      = ST_FAULT;
              set_stuck = 1'b1;
            end
          end else begin
            half_run = 1'b1;
            if (half_exp) st_n = ST_STOP_RELEASE;
          end
        end else begin
          half_run = 1'b1;
          if (half_exp) step_n = step + 2'd1;
        end
      end
      ST_STOP_RELEASE: begin
        half_run = 1'b1;
        if (half_exp) begin
          if (scl_s && sda_s) begin
            st_n     = ST_DONE;
            set_done = 1'b1;
          end else begin
            st_n     = ST_FAULT;
            set_fail = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      step        <= STOP_CLK_LOW;
      cnt         <= '0;
      scl_pull_o  <= 1'b0;
      sda_pull_o  <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      clk_stuck_o <= 1'b0;
      fail_o      <= 1'b0;
    end else begin
      st         <= st_n;
      step       <= step_n;
      cnt        <= cnt_n;
      scl_pull_o <= (st_n == ST_PULSE_LOW) ||
                    ((st_n == ST_STOP_SETUP) && (step_n != STOP_CLK_REL));
      sda_pull_o <= (st_n == ST_STOP_SETUP) && (step_n != STOP_CLK_LOW);
      busy_o     <= !((st_n == ST_IDLE) || (st_n == ST_DONE) || (st_n == ST_FAULT));
      done_o      <= !clr_status && (done_o || set_done);
      clk_stuck_o <= !clr_status && (clk_stuck_o || set_stuck);
      fail_o      <= !clr_status && (fail_o || set_fail);
    end
  end

  assign pulse_cnt_o = cnt;

  // R2
  stuck_no_pull_chk: assert property (@(posedge clk) disable iff (rst)
    clk_stuck_o |-> (!scl_pull_o && !sda_pull_o));
  // R4
  sda_pull_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> ($past(scl_pull_o) && scl_pull_o));
  // R7
  pulse_cap_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_cnt_o <= CNT_MAX);
  // R11
  status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, clk_stuck_o, fail_o}));
  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);
  // R11
  busy_status_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !(done_o || clk_stuck_o || fail_o));
  // R1
  done_lines_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(scl_s && sda_s));
endmodule

// File: tb/test_i2c_bus_unhang.sv
module test_i2c_bus_unhang;
  localparam int HALF = 4;
  localparam int STUCK = 40;
  localparam int MAXP = 9;
  localparam int CW = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic scl_pull, sda_pull, busy, done, stuck, fail;
  logic [CW-1:0] pcnt;

  // bus model and bench-side agents
  logic force_scl_low = 1'b0;
  logic armed = 1'b0;
  int   release_after = 0;
  int   stretch_ep = 0;
  int   stretch_len = 0;
  logic mon_clear = 1'b0;

  int   fall_cnt, stretch_cnt, episodes, ep_len, first_len, stops, cyc, rel_cyc, hi_gap;
  logic sda_pull_seen, bad_sda_order, prev_pull, prev_scl, prev_sda, prev_sda_pull;

  wire slave_sda_hold = armed && (fall_cnt < release_after);
  wire scl_line = !scl_pull && !force_scl_low && (stretch_cnt == 0);
  wire sda_line = !sda_pull && !slave_sda_hold;

  int n_checks = 0;
  int n_fail = 0;

  i2c_bus_unhang #(.HALF_CYCLES(HALF), .STUCK_LIMIT(STUCK), .MAX_PULSES(MAXP), .SYNC_STAGES(2))
  i_i2c_bus_unhang (
    .clk(clk), .rst(rst), .start_i(start_i), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .busy_o(busy), .done_o(done),
    .clk_stuck_o(stuck), .fail_o(fail), .pulse_cnt_o(pcnt));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clear) begin
      fall_cnt <= 0; stretch_cnt <= 0; episodes <= 0; ep_len <= 0; first_len <= 0;
      stops <= 0; rel_cyc <= -1000; hi_gap <= -1; sda_pull_seen <= 1'b0;
      bad_sda_order <= 1'b0; prev_pull <= 1'b0; prev_scl <= 1'b1; prev_sda <= 1'b1;
      prev_sda_pull <= 1'b0;
    end else begin
      prev_pull <= scl_pull; prev_scl <= scl_line; prev_sda <= sda_line;
      prev_sda_pull <= sda_pull;
      if (armed && prev_scl && !scl_line) fall_cnt <= fall_cnt + 1;
      if (scl_pull && !prev_pull) begin
        episodes <= episodes + 1;
        ep_len <= 1;
        if (episodes + 1 == stretch_ep) stretch_cnt <= stretch_len;
        if (rel_cyc >= 0 && hi_gap < 0) hi_gap <= cyc - rel_cyc;
      end else if (scl_pull) begin
        ep_len <= ep_len + 1;
      end
      if (!scl_pull && prev_pull && episodes == 1) first_len <= ep_len;
      if (!scl_pull && stretch_cnt > 0) begin
        stretch_cnt <= stretch_cnt - 1;
        if (stretch_cnt == 1) rel_cyc <= cyc;
      end
      if (sda_pull) sda_pull_seen <= 1'b1;
      if (sda_pull && !prev_sda_pull && !prev_pull) bad_sda_order <= 1'b1;
      if (scl_line && prev_scl && sda_line && !prev_sda) stops <= stops + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lo);
    n_checks++;
    if (act < lo) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected >= %0d", req, act, lo);
    end
  endtask

  // configure agents, start, wait for the end of the attempt
  task automatic launch(input logic arm, input int rel, input logic hold_clk,
                        input int s_ep, input int s_len, input logic extra_start);
    @(negedge clk);
    armed = arm; release_after = rel; force_scl_low = hold_clk;
    stretch_ep = s_ep; stretch_len = s_len; mon_clear = 1'b1;
    @(negedge clk);
    mon_clear = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 2000 && busy; i++) begin
      @(negedge clk);
      if (extra_start && i == 20) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic tc_reset;
    chk("reset scl_pull", scl_pull, 0);
    chk("reset sda_pull", sda_pull, 0);
    chk("reset busy", busy, 0);
    chk("reset status", {done, stuck, fail}, 0);
    chk("reset count", pcnt, 0);
  endtask

  task automatic tc_idle_bus;
    launch(1'b0, 0, 1'b0, 0, 0, 1'b0);
    chk("R1 done", done, 1);
    chk("R1 count", pcnt, 0);
    chk("R1 scl pulses", episodes, 0);
    chk("R1 no sda pull", sda_pull_seen, 0);
    chk("R1 no stop", stops, 0);
  endtask

  task automatic tc_stuck_clock;
    launch(1'b1, 100, 1'b1, 0, 0, 1'b0);
    chk("R2 stuck", stuck, 1);
    chk("R2 no done/fail", {done, fail}, 0);
    chk("R2 no scl pull", episodes, 0);
    chk("R2 no sda pull", sda_pull_seen, 0);
    @(negedge clk);
    force_scl_low = 1'b0;
  endtask

  task automatic tc_one_pulse;
    launch(1'b1, 1, 1'b0, 0, 0, 1'b0);
    chk("R3 done", done, 1);
    chk("R5 count", pcnt, 1);
    chk("R3 pull episodes", episodes, 2);
    chk("R10 low width", first_len, HALF);
    chk("R8 stop seen", stops, 1);
    chk("R8 lines high", {scl_line, sda_line}, 3);
    chk("R4 sda order", bad_sda_order, 0);
  endtask

  task automatic tc_five_busy_start;
    launch(1'b1, 5, 1'b0, 0, 0, 1'b1);
    chk("R5 done", done, 1);
    chk("R11 count after busy start", pcnt, 5);
    chk("R11 episodes", episodes, 6);
    repeat (30) @(negedge clk);
    chk("R11 done held", done, 1);
    chk("R11 onehot", {stuck, fail}, 0);
  endtask

  task automatic tc_nine;
    launch(1'b1, 9, 1'b0, 0, 0, 1'b0);
    chk("R7 limit done", done, 1);
    chk("R7 limit count", pcnt, 9);
  endtask

  task automatic tc_never_free;
    launch(1'b1, 1000, 1'b0, 0, 0, 1'b0);
    chk("R7 fail", fail, 1);
    chk("R7 count", pcnt, MAXP);
    chk("R7 episodes", episodes, MAXP);
    chk("R7 no stop", stops, 0);
    chk("R4 no sda pull", sda_pull_seen, 0);
    armed = 1'b0;
  endtask

  task automatic tc_stretch;
    launch(1'b1, 3, 1'b0, 2, 12, 1'b0);
    chk("R6 done", done, 1);
    chk("R6 count", pcnt, 3);
    chk_ge("R6 high after stretch", hi_gap, HALF);
  endtask

  task automatic tc_stretch_forever;
    launch(1'b1, 3, 1'b0, 1, 100000, 1'b0);
    chk("R9 stuck", stuck, 1);
    chk("R9 count", pcnt, 0);
    chk("R9 episodes", episodes, 1);
    @(negedge clk);
    mon_clear = 1'b1;
    @(negedge clk);
    mon_clear = 1'b0;
  endtask

  initial begin
    mon_clear = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    mon_clear = 1'b0;
    @(negedge clk);
    tc_reset();
    tc_idle_bus();
    tc_stuck_clock();
    tc_one_pulse();
    tc_five_busy_start();
    tc_nine();
    tc_never_free();
    tc_stretch();
    tc_stretch_forever();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule